// File: doc/BRIEF.md
# Configurable Programmable-Logic Macrocell

This block models a single macrocell of a programmable-logic array. A set of product terms is formed, each as an AND over a bank of routed signals and shared expander lines, with every literal taken true, complemented or left out. Static configuration then gives each term one job. A term can feed the OR/XOR sum, drive a register control (clock, enable, preset or clear), be lent to a neighbouring cell as a parallel expander, or be inverted and offered back to the array as a shareable expander.

The sum passes through an XOR stage, whose second input is a polarity bit combined with any terms assigned to it. The result either leaves the cell combinatorially or is loaded into a register that acts as a D or a T flip-flop. That register is clocked by a chosen global clock or by a product-term clock. A fast-input option lets it load directly from the pin. One output drives both the I/O path and the feedback into the array.

The model runs on one system clock `clk`. It samples the selected register clock and updates the register on the system edge where that clock is first seen high. Preset and clear act on the output at once and force the stored state at the next system edge.

Top module: `pld_macrocell`

## Requirements
- R1: Product term p is the AND of all literals it selects. Input i of term p is bit p*52+i of `and_true`, which takes the input true, and of `and_comp`, which takes it inverted. Inputs 0..35 are `sig_in` and inputs 36..51 are `exp_in`. A term with no literals is 1, and a term that takes the same input in both polarities is 0.
- R2: Each term's 3-bit route code sits at bits [3p+2:3p] of `pt_route`. The codes are 0 sum, 1 XOR, 2 clock, 3 enable, 4 preset, 5 clear, 6 lend and 7 share. The sum is the OR of the terms routed to sum, plus `pex_in` when `cfg_pex_take` is 1. Terms routed to lend are left out of the sum, and their OR drives `pex_out`.
- R3: The logic value is sum XOR `cfg_xor_pol` XOR (the OR of the terms routed to XOR).
- R4: `shx_out` is the inverse of the OR of the terms routed to share, so it is 1 when no term is routed there. Shared terms do not enter the sum.
- R5: With `cfg_bypass`=1, `io_out` follows the logic value in the same cycle. `fb_out` equals `io_out` at all times.
- R6: In register mode (`cfg_bypass`=0, `cfg_tff`=0), the register loads the logic value on the system edge where the selected clock is first sampled high after being low. At any other time it holds.
- R7: A `cfg_clk_sel` value below 2 selects `gclk[cfg_clk_sel]`. Values 2 and 3 select the OR of the terms routed to clock. Edges on a clock that is not selected have no effect.
- R8: With `cfg_ena_pt`=1, a clock edge loads only when the OR of the terms routed to enable is 1. With `cfg_ena_pt`=0 the register is always enabled.
- R9: With `cfg_tff`=1, an enabled clock edge inverts the stored bit when the data is 1 and keeps it when the data is 0.
- R10: With `cfg_fast_in`=1, the register data comes from `pin_in` instead of the logic value.
- R11: Preset, the OR of the terms routed to preset, forces the register output to 1 at once. Clear forces it to 0 at once and takes priority over preset. Clear comes from `gclr_n` low when `cfg_clr_glob`=1, and from the OR of the terms routed to clear otherwise. Either one also sets the stored bit at the next system edge.
- R12: While `rst_n` is low the stored bit is 0, so in register mode `io_out` is 0. Release passes through a two-stage synchronizer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| gclk | input | N_GCLK | Global register clocks |
| gclr_n | input | 1 | Global active-low clear |
| sig_in | input | N_SIG | Routed array signals |
| exp_in | input | N_EXP | Shareable expander lines |
| pin_in | input | 1 | Pin input for the fast-input path |
| pex_in | input | 1 | Parallel expander from the neighbouring cell |
| and_true | input | N_PT*N_IN | True-literal selection mask |
| and_comp | input | N_PT*N_IN | Complement-literal selection mask |
| pt_route | input | N_PT*3 | Per-term route code |
| cfg_xor_pol | input | 1 | XOR polarity bit |
| cfg_pex_take | input | 1 | Add the borrowed expander to the sum |
| cfg_fast_in | input | 1 | Register data from the pin |
| cfg_tff | input | 1 | T-type register |
| cfg_bypass | input | 1 | Combinatorial output |
| cfg_clk_sel | input | CSEL_W | Register clock source |
| cfg_ena_pt | input | 1 | Use the product-term enable |
| cfg_clr_glob | input | 1 | Clear from the global line |
| io_out | output | 1 | Output to the I/O path |
| fb_out | output | 1 | Feedback to the routing array |
| shx_out | output | 1 | Shareable expander output (inverted) |
| pex_out | output | 1 | Lent terms to the neighbouring cell |

## Verification
The combinatorial path is driven with literal patterns that separate a true literal from a complemented one, a routed signal from an expander line, an empty term from a contradictory one, and a summed term from a lent or shared one. For the XOR stage, the polarity bit and an XOR-routed term are each toggled alone against a fixed sum. The register is driven with sequences that hold each clock source high across several data changes, which tells an edge load apart from a level load. Edges on the clock that is not selected are driven, and so are edges with the enable term low. Toggle, fast-input and preset/clear sequences, including preset and clear together and a term clear while the global clear is chosen, show the mode and priority of each control.

// File: rtl/pld_mc_pkg.sv
package pld_mc_pkg;
  localparam int ROUTE_W = 3;

  typedef enum logic [ROUTE_W-1:0] {
    RT_SUM   = 3'd0,
    RT_XOR   = 3'd1,
    RT_CLK   = 3'd2,
    RT_ENA   = 3'd3,
    RT_PRE   = 3'd4,
    RT_CLR   = 3'd5,
    RT_LEND  = 3'd6,
    RT_SHARE = 3'd7
  } route_e;

  // OR of the terms assigned to each role
  typedef struct packed {
    logic sum;
    logic xin;
    logic clk;
    logic ena;
    logic pre;
    logic clr;
    logic lend;
    logic share;
  } role_t;
endpackage

// File: rtl/pld_mc_rst_sync.sv
module pld_mc_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic stage0_q;
  logic stage1_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage0_q <= 1'b0;
      stage1_q <= 1'b0;
    end else begin
      stage0_q <= 1'b1;
      stage1_q <= stage0_q;
    end
  end

  assign rst_sync_n = stage1_q;
endmodule

// File: rtl/pld_mc_and_array.sv
module pld_mc_and_array #(
  parameter int N_IN = 52,
  parameter int N_PT = 5
) (
  input  logic [N_IN-1:0]      in_vec,
  input  logic [N_PT*N_IN-1:0] lit_true,
  input  logic [N_PT*N_IN-1:0] lit_comp,
  output logic [N_PT-1:0]      pterm
);
  for (genvar p = 0; p < N_PT; p++) begin : g_term
    logic [N_IN-1:0] t_sel;
    logic [N_IN-1:0] c_sel;
    logic [N_IN-1:0] lit_ok;

    assign t_sel  = lit_true[p*N_IN +: N_IN];
    assign c_sel  = lit_comp[p*N_IN +: N_IN];
    // a literal passes when it is unused or matches its polarity
    assign lit_ok = (~t_sel | in_vec) & (~c_sel | ~in_vec);
    assign pterm[p] = &lit_ok;
  end
endmodule

// File: rtl/pld_mc_term_router.sv
module pld_mc_term_router
  import pld_mc_pkg::*;
#(
  parameter int N_PT = 5
) (
  input  logic [N_PT-1:0]         pterm,
  input  logic [N_PT*ROUTE_W-1:0] route,
  output role_t                   role
);
  logic [N_PT-1:0] m_sum, m_xin, m_clk, m_ena, m_pre, m_clr, m_lend, m_share;

  for (genvar p = 0; p < N_PT; p++) begin : g_dec
    route_e code;
    assign code       = route_e'(route[p*ROUTE_W +: ROUTE_W]);
    assign m_sum[p]   = pterm[p] & (code == RT_SUM);
    assign m_xin[p]   = pterm[p] & (code == RT_XOR);
    assign m_clk[p]   = pterm[p] & (code == RT_CLK);
    assign m_ena[p]   = pterm[p] & (code == RT_ENA);
    assign m_pre[p]   = pterm[p] & (code == RT_PRE);
    assign m_clr[p]   = pterm[p] & (code == RT_CLR);
    assign m_lend[p]  = pterm[p] & (code == RT_LEND);
    assign m_share[p] = pterm[p] & (code == RT_SHARE);
  end

  always_comb begin
    role.sum   = |m_sum;
    role.xin   = |m_xin;
    role.clk   = |m_clk;
    role.ena   = |m_ena;
    role.pre   = |m_pre;
    role.clr   = |m_clr;
    role.lend  = |m_lend;
    role.share = |m_share;
  end
endmodule

// File: rtl/pld_mc_register.sv
module pld_mc_register (
  input  logic clk,
  input  logic rst_n,
  input  logic clk_src,
  input  logic ena,
  input  logic d,
  input  logic tff,
  input  logic pre,
  input  logic clr,
  output logic q_out
);
  logic q_reg, q_nxt;
  logic src_prev_q;
  logic edge_c;
  logic d_eff;

  always_comb begin
    edge_c = clk_src & ~src_prev_q;
    d_eff  = tff ? (q_reg ^ d) : d;
    if (clr) begin
      q_nxt = 1'b0;
    end else if (pre) begin
      q_nxt = 1'b1;
    end else if (edge_c && ena) begin
      q_nxt = d_eff;
    end else begin
      q_nxt = q_reg;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_reg      <= 1'b0;
      src_prev_q <= 1'b1;
    end else begin
      q_reg      <= q_nxt;
      src_prev_q <= clk_src;
    end
  end

  assign q_out = clr ? 1'b0 : (pre ? 1'b1 : q_reg);

  p_hold_no_edge_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!edge_c && !clr && !pre) |=> (q_reg == $past(q_reg)));

  p_enable_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_c && !ena && !clr && !pre) |=> $stable(q_reg));

  p_toggle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_c && ena && tff && d && !clr && !pre) |=> (q_reg != $past(q_reg)));

  p_clear_state_r11: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> !q_reg);
endmodule

// File: rtl/pld_macrocell.sv
module pld_macrocell
  import pld_mc_pkg::*;
#(
  parameter int N_SIG  = 36,
  parameter int N_EXP  = 16,
  parameter int N_PT   = 5,
  parameter int N_GCLK = 2,
  localparam int N_IN   = N_SIG + N_EXP,
  localparam int CSEL_W = $clog2(N_GCLK + 1)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [N_GCLK-1:0]       gclk,
  input  logic                    gclr_n,
  input  logic [N_SIG-1:0]        sig_in,
  input  logic [N_EXP-1:0]        exp_in,
  input  logic                    pin_in,
  input  logic                    pex_in,
  input  logic [N_PT*N_IN-1:0]    and_true,
  input  logic [N_PT*N_IN-1:0]    and_comp,
  input  logic [N_PT*ROUTE_W-1:0] pt_route,
  input  logic                    cfg_xor_pol,
  input  logic                    cfg_pex_take,
  input  logic                    cfg_fast_in,
  input  logic                    cfg_tff,
  input  logic                    cfg_bypass,
  input  logic [CSEL_W-1:0]       cfg_clk_sel,
  input  logic                    cfg_ena_pt,
  input  logic                    cfg_clr_glob,
  output logic                    io_out,
  output logic                    fb_out,
  output logic                    shx_out,
  output logic                    pex_out
);
  logic            rst_sync_n;
  logic [N_PT-1:0] pterm;
  role_t           role;
  logic            sum_v, logic_v, d_v;
  logic            clk_src, ena_v, clr_v, q_v;

  pld_mc_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  pld_mc_and_array #(.N_IN(N_IN), .N_PT(N_PT)) u_and (
    .in_vec   ({exp_in, sig_in}),
    .lit_true (and_true),
    .lit_comp (and_comp),
    .pterm    (pterm)
  );

  pld_mc_term_router #(.N_PT(N_PT)) u_route (
    .pterm (pterm),
    .route (pt_route),
    .role  (role)
  );

  always_comb begin
    sum_v   = role.sum | (cfg_pex_take & pex_in);
    logic_v = sum_v ^ cfg_xor_pol ^ role.xin;
    d_v     = cfg_fast_in ? pin_in : logic_v;
    ena_v   = cfg_ena_pt ? role.ena : 1'b1;
    clr_v   = cfg_clr_glob ? ~gclr_n : role.clr;
    clk_src = role.clk;
    for (int g = 0; g < N_GCLK; g++) begin
      if (cfg_clk_sel == CSEL_W'(g)) clk_src = gclk[g];
    end
  end

  pld_mc_register u_reg (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .clk_src (clk_src),
    .ena     (ena_v),
    .d       (d_v),
    .tff     (cfg_tff),
    .pre     (role.pre),
    .clr     (clr_v),
    .q_out   (q_v)
  );

  assign io_out  = cfg_bypass ? logic_v : q_v;
  assign fb_out  = io_out;
  assign shx_out = ~role.share;
  assign pex_out = role.lend;

  p_clear_wins_r11: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!cfg_bypass && clr_v) |-> !io_out);

  p_preset_out_r11: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!cfg_bypass && role.pre && !clr_v) |-> io_out);
endmodule

// File: tb/pld_macrocell_bench.sv
module pld_macrocell_bench;
  localparam int CLK_P  = 10;
  localparam int N_SIG  = 36;
  localparam int N_EXP  = 16;
  localparam int N_PT   = 5;
  localparam int N_GCLK = 2;
  localparam int N_IN   = N_SIG + N_EXP;
  localparam int CSEL_W = 2;

  logic                 clk = 1'b0;
  logic                 rst_n;
  logic [N_GCLK-1:0]    gclk;
  logic                 gclr_n;
  logic [N_SIG-1:0]     sig_in;
  logic [N_EXP-1:0]     exp_in;
  logic                 pin_in, pex_in;
  logic [N_PT*N_IN-1:0] and_true, and_comp;
  logic [N_PT*3-1:0]    pt_route;
  logic                 cfg_xor_pol, cfg_pex_take, cfg_fast_in, cfg_tff, cfg_bypass;
  logic [CSEL_W-1:0]    cfg_clk_sel;
  logic                 cfg_ena_pt, cfg_clr_glob;
  logic                 io_out, fb_out, shx_out, pex_out;

  int errors = 0;
  int checks = 0;

  typedef struct {
    logic  io;
    logic  shx;
    logic  pex;
    bit    use_side;
    string tag;
  } item_t;
  item_t exp_q[$];

  pld_macrocell u_pld_macrocell (
    .clk(clk), .rst_n(rst_n), .gclk(gclk), .gclr_n(gclr_n),
    .sig_in(sig_in), .exp_in(exp_in), .pin_in(pin_in), .pex_in(pex_in),
    .and_true(and_true), .and_comp(and_comp), .pt_route(pt_route),
    .cfg_xor_pol(cfg_xor_pol), .cfg_pex_take(cfg_pex_take),
    .cfg_fast_in(cfg_fast_in), .cfg_tff(cfg_tff), .cfg_bypass(cfg_bypass),
    .cfg_clk_sel(cfg_clk_sel), .cfg_ena_pt(cfg_ena_pt),
    .cfg_clr_glob(cfg_clr_glob),
    .io_out(io_out), .fb_out(fb_out), .shx_out(shx_out), .pex_out(pex_out)
  );

  always #(CLK_P/2) clk = ~clk;

  // monitor: compares queued expectations half a cycle after each edge
  always @(negedge clk) begin
    #1;
    while (exp_q.size() > 0) begin
      item_t it;
      it = exp_q.pop_front();
      checks++;
      if (io_out !== it.io) begin
        errors++;
        $display("FAIL %s io_out actual=%b expected=%b", it.tag, io_out, it.io);
      end
      checks++;
      if (fb_out !== io_out) begin
        errors++;
        $display("FAIL R5 fb_out actual=%b expected=%b", fb_out, io_out);
      end
      if (it.use_side) begin
        checks++;
        if (shx_out !== it.shx || pex_out !== it.pex) begin
          errors++;
          $display("FAIL %s shx/pex actual=%b%b expected=%b%b",
                   it.tag, shx_out, pex_out, it.shx, it.pex);
        end
      end
    end
  end

  task automatic drv();
    @(negedge clk);
    #2;
  endtask

  task automatic exp_io(input logic v, input string tag);
    item_t it;
    @(posedge clk);
    #1;
    it.io = v; it.shx = 1'b0; it.pex = 1'b0; it.use_side = 1'b0; it.tag = tag;
    exp_q.push_back(it);
  endtask

  task automatic exp_all(input logic v, input logic s, input logic p, input string tag);
    item_t it;
    @(posedge clk);
    #1;
    it.io = v; it.shx = s; it.pex = p; it.use_side = 1'b1; it.tag = tag;
    exp_q.push_back(it);
  endtask

  task automatic clr_pt(input int p);
    for (int i = 0; i < N_IN; i++) begin
      and_true[p*N_IN+i] = 1'b0;
      and_comp[p*N_IN+i] = 1'b0;
    end
  endtask

  task automatic kill_pt(input int p);
    clr_pt(p);
    and_true[p*N_IN] = 1'b1;
    and_comp[p*N_IN] = 1'b1;
  endtask

  task automatic lit(input int p, input int i, input bit comp);
    if (comp) and_comp[p*N_IN+i] = 1'b1;
    else      and_true[p*N_IN+i] = 1'b1;
  endtask

  task automatic set_rt(input int p, input logic [2:0] r);
    pt_route[p*3 +: 3] = r;
  endtask

  task automatic summary();
    $display("  Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin
    #(CLK_P*150000);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    rst_n = 1'b0; gclk = '0; gclr_n = 1'b1; sig_in = '0; exp_in = '0;
    pin_in = 1'b0; pex_in = 1'b0; and_true = '0; and_comp = '0; pt_route = '0;
    cfg_xor_pol = 1'b0; cfg_pex_take = 1'b0; cfg_fast_in = 1'b0; cfg_tff = 1'b0;
    cfg_bypass = 1'b0; cfg_clk_sel = '0; cfg_ena_pt = 1'b0; cfg_clr_glob = 1'b0;

    // R12: register output held at 0 during reset, empty terms summed
    drv(); exp_all(1'b0, 1'b1, 1'b0, "R12");
    drv(); exp_io(1'b0, "R12");
    drv(); rst_n = 1'b1;
    repeat (3) begin drv(); exp_io(1'b0, "R12"); end

    // R1: literal selection, bypass mode
    drv(); cfg_bypass = 1'b1;
    for (int p = 1; p < N_PT; p++) kill_pt(p);
    clr_pt(0); lit(0, 3, 0); lit(0, 7, 1);
    sig_in[3] = 1'b1; sig_in[7] = 1'b0; exp_io(1'b1, "R1");
    drv(); sig_in[7] = 1'b1; exp_io(1'b0, "R1");
    drv(); sig_in[3] = 1'b0; sig_in[7] = 1'b0; exp_io(1'b0, "R1");
    drv(); clr_pt(0); exp_io(1'b1, "R1");
    drv(); lit(0, 3, 0); lit(0, 3, 1); exp_io(1'b0, "R1");
    drv(); clr_pt(0); lit(0, N_SIG+5, 0); exp_in[5] = 1'b1; exp_io(1'b1, "R1");
    drv(); exp_in[5] = 1'b0; exp_io(1'b0, "R1");

    // R2: parallel expander lend and take
    drv(); clr_pt(0); lit(0, 1, 0); clr_pt(1); lit(1, 2, 0); set_rt(1, 3'd6);
    sig_in[1] = 1'b0; sig_in[2] = 1'b1; exp_all(1'b0, 1'b1, 1'b1, "R2");
    drv(); cfg_pex_take = 1'b1; pex_in = 1'b1; exp_io(1'b1, "R2");
    drv(); cfg_pex_take = 1'b0; exp_io(1'b0, "R2");
    drv(); sig_in[1] = 1'b1; sig_in[2] = 1'b0; exp_all(1'b1, 1'b1, 1'b0, "R2");

    // R3: XOR stage
    drv(); kill_pt(1); set_rt(1, 3'd0); sig_in[1] = 1'b0; cfg_xor_pol = 1'b1;
    exp_io(1'b1, "R3");
    drv(); clr_pt(2); lit(2, 4, 0); set_rt(2, 3'd1); sig_in[4] = 1'b1;
    exp_io(1'b0, "R3");
    drv(); sig_in[1] = 1'b1; exp_io(1'b1, "R3");
    drv(); cfg_xor_pol = 1'b0; sig_in[4] = 1'b0; exp_io(1'b1, "R3");

    // R4: shareable expander
    drv(); kill_pt(2); set_rt(2, 3'd0); sig_in[1] = 1'b0;
    clr_pt(3); lit(3, 5, 0); set_rt(3, 3'd7); sig_in[5] = 1'b1;
    exp_all(1'b0, 1'b0, 1'b0, "R4");
    drv(); sig_in[5] = 1'b0; exp_all(1'b0, 1'b1, 1'b0, "R4");

    // R6: D register on gclk[0]
    drv(); kill_pt(3); set_rt(3, 3'd0); cfg_bypass = 1'b0;
    clr_pt(0); lit(0, 10, 0); sig_in[10] = 1'b1; exp_io(1'b0, "R6");
    drv(); gclk[0] = 1'b1; exp_io(1'b1, "R6");
    drv(); sig_in[10] = 1'b0; exp_io(1'b1, "R6");
    drv(); gclk[0] = 1'b0; exp_io(1'b1, "R6");
    drv(); gclk[0] = 1'b1; exp_io(1'b0, "R6");
    drv(); gclk[0] = 1'b0; exp_io(1'b0, "R6");

    // R7: clock source selection
    drv(); cfg_clk_sel = 2'd1; sig_in[10] = 1'b1; gclk[0] = 1'b1; exp_io(1'b0, "R7");
    drv(); gclk[1] = 1'b1; exp_io(1'b1, "R7");
    drv(); gclk[1] = 1'b0; cfg_clk_sel = 2'd2; clr_pt(1); lit(1, 11, 0);
    set_rt(1, 3'd2); sig_in[11] = 1'b0; sig_in[10] = 1'b0; exp_io(1'b1, "R7");
    drv(); sig_in[11] = 1'b1; exp_io(1'b0, "R7");
    drv(); sig_in[11] = 1'b0; exp_io(1'b0, "R7");

    // R8: product-term enable
    drv(); cfg_clk_sel = 2'd0; gclk[0] = 1'b0; cfg_ena_pt = 1'b1;
    clr_pt(2); lit(2, 12, 0); set_rt(2, 3'd3); sig_in[12] = 1'b0;
    sig_in[10] = 1'b1; exp_io(1'b0, "R8");
    drv(); gclk[0] = 1'b1; exp_io(1'b0, "R8");
    drv(); gclk[0] = 1'b0; sig_in[12] = 1'b1; exp_io(1'b0, "R8");
    drv(); gclk[0] = 1'b1; exp_io(1'b1, "R8");

    // R9: toggle register
    drv(); cfg_ena_pt = 1'b0; cfg_tff = 1'b1; gclk[0] = 1'b0; exp_io(1'b1, "R9");
    drv(); gclk[0] = 1'b1; exp_io(1'b0, "R9");
    drv(); gclk[0] = 1'b0; exp_io(1'b0, "R9");
    drv(); gclk[0] = 1'b1; exp_io(1'b1, "R9");
    drv(); gclk[0] = 1'b0; sig_in[10] = 1'b0; exp_io(1'b1, "R9");
    drv(); gclk[0] = 1'b1; exp_io(1'b1, "R9");

    // R10: fast input from pin
    drv(); cfg_tff = 1'b0; cfg_fast_in = 1'b1; pin_in = 1'b0; sig_in[10] = 1'b1;
    gclk[0] = 1'b0; exp_io(1'b1, "R10");
    drv(); gclk[0] = 1'b1; exp_io(1'b0, "R10");
    drv(); gclk[0] = 1'b0; pin_in = 1'b1; exp_io(1'b0, "R10");
    drv(); gclk[0] = 1'b1; exp_io(1'b1, "R10");

    // R11: preset, clear and clear source
    drv(); cfg_fast_in = 1'b0; gclk[0] = 1'b0;
    clr_pt(3); lit(3, 13, 0); set_rt(3, 3'd4);
    clr_pt(4); lit(4, 14, 0); set_rt(4, 3'd5);
    sig_in[13] = 1'b0; sig_in[14] = 1'b1; exp_io(1'b0, "R11");
    drv(); sig_in[14] = 1'b0; exp_io(1'b0, "R11");
    drv(); sig_in[13] = 1'b1; exp_io(1'b1, "R11");
    drv(); sig_in[13] = 1'b0; exp_io(1'b1, "R11");
    drv(); sig_in[13] = 1'b1; sig_in[14] = 1'b1; exp_io(1'b0, "R11");
    drv(); sig_in[13] = 1'b0; sig_in[14] = 1'b0; exp_io(1'b0, "R11");
    drv(); sig_in[13] = 1'b1; exp_io(1'b1, "R11");
    drv(); sig_in[13] = 1'b0; cfg_clr_glob = 1'b1; sig_in[14] = 1'b1;
    exp_io(1'b1, "R11");
    drv(); gclr_n = 1'b0; exp_io(1'b0, "R11");
    drv(); gclr_n = 1'b1; sig_in[14] = 1'b0; exp_io(1'b0, "R11");

    drv();
    drv();
    summary();
    $finish;
  end
endmodule